// File: doc/BRIEF.md
# Double-Buffered Palette Lookup

The block turns 8-bit indexed pixels into 24-bit RGB colours through a 256-entry colour table that has two banks. One bank feeds the pixel path. Software writes go to the other bank. When the hidden bank holds a complete new palette, software flips a bank-request bit in a control register. The hardware makes that bank visible at the next rising edge of vertical blank, so a palette change never lands part way through a frame.

The control register holds the request bit and a read-only status bit. The status bit reports which bank is actually displayed. When the two bits agree, the last swap has taken effect and software may refill the hidden bank. The pixel path registers its result once, so the colour appears one clock after the index. A valid flag travels with the colour.

Top module: `pal_lut_dbuf`

## Requirements
- R1: A write to byte address TABLE_BASE + 4*n (TABLE_BASE = 0x400, n in 0..255) stores reg_wdata_i[23:0] as entry n. A write to an address whose two low bits are not zero, or that lies outside the table and is not the control address, changes no entry.
- R2: Table writes always go to the bank that is not displayed. A write never changes the colour returned for any index of the displayed bank.
- R3: The control register is at address 0x018. Bit 0 is the bank request; a write stores reg_wdata_i[0] there. Bit 1 is the displayed-bank status and ignores writes. A read of 0x018 returns {status, request} in bits [1:0], with the other bits zero. Any other address reads as zero.
- R4: On the first clock at which vblank_i is high after having been low, the displayed bank takes the value of the request bit, and the status bit then reads the same value.
- R5: The displayed bank and the status bit do not change at any other time, including while vblank_i stays high or stays low.
- R6: pix_valid_o equals pix_valid_i from one clock earlier. When pix_valid_o is high, pix_rgb_o holds the displayed-bank entry for the index presented on that earlier clock, as red [23:16], green [15:8] and blue [7:0].
- R7: pix_rgb_o is zero whenever pix_valid_o is low.
- R8: After reset, bank 0 is displayed, the request bit is 0 and pix_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Read data for reg_addr_i, combinational |
| vblank_i | input | 1 | Vertical blank level; its rising edge is the swap point |
| pix_valid_i | input | 1 | Pixel index valid |
| pix_idx_i | input | 8 | Pixel index |
| pix_valid_o | output | 1 | Colour valid, one clock after pix_valid_i |
| pix_rgb_o | output | 24 | Looked-up colour |

## Verification
The bench targets the swap point. It holds vblank high across a change of the request bit and checks that no second swap occurs. A design that swapped on the vblank level rather than its edge would flip banks mid-frame there. It writes to the hidden bank while the pixel path reads the same index, which exposes any write reaching the displayed bank. It writes a 1 to the status bit and sends a misaligned table write, to catch decoding that is too loose. It also checks the first and last table entries and the one-cycle pairing of valid and colour, so an off-by-one in indexing or in pipeline depth shows up as a wrong colour or a shifted valid.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int unsigned REQ_BIT  = 0;
  localparam int unsigned STAT_BIT = 1;
  localparam int unsigned NBANKS   = 2;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_reg_dec.sv
module pal_reg_dec #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned TABLE_BASE = 12'h400,
  parameter int unsigned CTRL_ADDR  = 12'h018
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tbl_we_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              ctrl_sel_o,
  output logic              ctrl_we_o
);
  localparam int unsigned SPAN = (1 << IDX_W) * 4;

  logic [ADDR_W:0] ofs;
  logic            in_tbl;

  always_comb begin
    ofs        = {1'b0, addr_i} - (ADDR_W+1)'(TABLE_BASE);
    in_tbl     = ({1'b0, addr_i} >= (ADDR_W+1)'(TABLE_BASE)) &&
                 (ofs < (ADDR_W+1)'(SPAN)) && (addr_i[1:0] == 2'b00);
    tbl_idx_o  = ofs[IDX_W+1:2];
    tbl_we_o   = we_i && in_tbl;
    ctrl_sel_o = (addr_i == ADDR_W'(CTRL_ADDR));
    ctrl_we_o  = we_i && ctrl_sel_o;
  end
endmodule

// File: rtl/pal_swap_ctrl.sv
module pal_swap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  input  logic ctrl_we_i,
  input  logic req_wdata_i,
  output logic req_o,
  output logic disp_bank_o
);
  logic vblank_q;
  logic vbl_rise;

  assign vbl_rise = vblank_i && !vblank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vblank_q    <= 1'b0;
      req_o       <= 1'b0;
      disp_bank_o <= 1'b0;
    end else begin
      vblank_q <= vblank_i;
      if (ctrl_we_i) req_o <= req_wdata_i;
      // swap uses the request held before any same-cycle write
      if (vbl_rise) disp_bank_o <= req_o;
    end
  end
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pal_lut_dbuf.sv
module pal_lut_dbuf
  import pal_lut_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned TABLE_BASE = 12'h400,
  parameter int unsigned CTRL_ADDR  = 12'h018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [23:0]       reg_wdata_i,
  output logic [23:0]       reg_rdata_o,
  input  logic              vblank_i,
  input  logic              pix_valid_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic              pix_valid_o,
  output logic [23:0]       pix_rgb_o
);
  localparam int unsigned DATA_W = $bits(rgb_t);

  logic              tbl_we, ctrl_sel, ctrl_we;
  logic [IDX_W-1:0]  tbl_idx;
  logic              req, disp_bank;
  logic [NBANKS-1:0] bank_we;
  logic [DATA_W-1:0] bank_rd [NBANKS];
  logic              valid_q, sel_q;

  pal_reg_dec #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .TABLE_BASE(TABLE_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .tbl_we_o  (tbl_we),
    .tbl_idx_o (tbl_idx),
    .ctrl_sel_o(ctrl_sel),
    .ctrl_we_o (ctrl_we)
  );

  pal_swap_ctrl u_swap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vblank_i   (vblank_i),
    .ctrl_we_i  (ctrl_we),
    .req_wdata_i(reg_wdata_i[REQ_BIT]),
    .req_o      (req),
    .disp_bank_o(disp_bank)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign bank_we[b] = tbl_we && (disp_bank != 1'(b));
    pal_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[b]),
      .waddr_i(tbl_idx),
      .wdata_i(reg_wdata_i[DATA_W-1:0]),
      .re_i   (pix_valid_i && (disp_bank == 1'(b))),
      .raddr_i(pix_idx_i),
      .rdata_o(bank_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      valid_q <= pix_valid_i;
      if (pix_valid_i) sel_q <= disp_bank;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (ctrl_sel) begin
      reg_rdata_o[REQ_BIT]  = req;
      reg_rdata_o[STAT_BIT] = disp_bank;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_rgb_o   = valid_q ? bank_rd[sel_q] : '0;
endmodule

// File: rtl/pal_lut_dbuf_chk.sv
module pal_lut_dbuf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vblank_i,
  input logic       pix_valid_i,
  input logic       pix_valid_o,
  input logic [23:0] pix_rgb_o,
  input logic       ctrl_we,
  input logic       req,
  input logic       disp_bank,
  input logic [1:0] bank_we
);
  AST_WE_HIDDEN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we) && !bank_we[disp_bank]); // R2

  AST_REQ_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req) |-> $past(ctrl_we)); // R3

  AST_SWAP_TAKES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_bank) |-> disp_bank == $past(req)); // R4

  AST_SWAP_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_bank) |-> ($past(vblank_i) && !$past(vblank_i, 2))); // R5

  AST_VALID_LAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o); // R6

  AST_VALID_LAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_valid_o); // R6

  AST_RGB_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> pix_rgb_o == 24'h0); // R7
endmodule

bind pal_lut_dbuf pal_lut_dbuf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vblank_i   (vblank_i),
  .pix_valid_i(pix_valid_i),
  .pix_valid_o(pix_valid_o),
  .pix_rgb_o  (pix_rgb_o),
  .ctrl_we    (ctrl_we),
  .req        (req),
  .disp_bank  (disp_bank),
  .bank_we    (bank_we)
);

// File: tb/pal_lut_dbuf_tb_top.sv
module pal_lut_dbuf_tb_top;
  localparam logic [11:0] TBASE = 12'h400;
  localparam logic [11:0] CTRL  = 12'h018;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [23:0] reg_wdata_i = '0;
  logic [23:0] reg_rdata_o;
  logic        vblank_i = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_idx_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pal_lut_dbuf dut_i (.*);

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [23:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_ctrl(input string req, input logic [1:0] exp);
    reg_addr_i = CTRL;
    #1;
    chk(req, reg_rdata_o, {22'b0, exp});
  endtask

  task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk_i);
    pix_valid_i = 1'b1; pix_idx_i = idx;
    @(negedge clk_i);
    pix_valid_i = 1'b0;
    chk({req, " valid"}, {23'b0, pix_valid_o}, 24'h1);
    chk(req, pix_rgb_o, exp);
  endtask

  task automatic vbl_rise;
    @(negedge clk_i); vblank_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    rd_ctrl("R8 ctrl", 2'b00);
    chk("R8 valid", {23'b0, pix_valid_o}, 24'h0);
    chk("R7 rgb idle", pix_rgb_o, 24'h0);
    reg_addr_i = 12'h01c; #1;
    chk("R3 other addr", reg_rdata_o, 24'h0);
  endtask

  task automatic t_fill_and_swap;
    wr(TBASE + 12'd0, 24'h112233);
    wr(TBASE + 12'd1020, 24'hAABBCC);
    wr(TBASE + 12'd28, 24'h445566);
    wr(TBASE + 12'd29, 24'hDEAD00);  // misaligned, ignored
    wr(12'h800, 24'h0BAD00);         // outside table, ignored
    wr(CTRL, 24'h1);
    rd_ctrl("R3 req readback", 2'b01);
    vbl_rise();
    rd_ctrl("R4 status follows", 2'b11);
    @(negedge clk_i); vblank_i = 1'b0;
    look("R1 entry 0", 8'd0, 24'h112233);
    look("R1 entry 255", 8'd255, 24'hAABBCC);
    look("R1 misaligned", 8'd7, 24'h445566);
    @(negedge clk_i);
    chk("R6 valid drop", {23'b0, pix_valid_o}, 24'h0);
    chk("R7 rgb zero", pix_rgb_o, 24'h0);
  endtask

  task automatic t_hidden_write;
    wr(TBASE + 12'd0, 24'h0F0F0F);   // goes to bank 0
    look("R2 displayed unchanged", 8'd0, 24'h112233);
    wr(CTRL, 24'h0);                 // status bit write 0 ignored
    rd_ctrl("R3 status write ignored", 2'b10);
    repeat (4) @(negedge clk_i);
    rd_ctrl("R5 no swap vblank low", 2'b10);
  endtask

  task automatic t_edge_only;
    vbl_rise();
    rd_ctrl("R4 swap to bank0", 2'b00);
    look("R4 bank0 colour", 8'd0, 24'h0F0F0F);
    wr(CTRL, 24'h3);                 // vblank still high
    repeat (3) @(negedge clk_i);
    rd_ctrl("R5 no swap vblank held", 2'b01);
    look("R5 still bank0", 8'd0, 24'h0F0F0F);
    @(negedge clk_i); vblank_i = 1'b0;
    vbl_rise();
    rd_ctrl("R4 swap to bank1", 2'b11);
    look("R4 bank1 colour", 8'd0, 24'h112233);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill_and_swap();
    t_hidden_write();
    t_edge_only();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule